// File: doc/BRIEF.md
# Oscillator Settling Timer

This block measures how long an external crystal oscillator has been running since it was switched on, so that software can wait for the clock to settle before switching the system onto it. A counter in the oscillator clock domain starts from zero when the oscillator is enabled and no stop request is pending. It stops at its largest interval and does not wrap. Eight elapsed-time flags are formed from the counter and brought into the system clock domain, where they can be read as an 8-bit status word.

The flags form a thermometer code. The shortest interval sits in bit 7 and the longest in bit 0. The intervals are not evenly spaced, and the exponents are set by a parameter: by default 2^8, 2^9, 2^10, 2^11, 2^13, 2^15, 2^17 and 2^18 oscillator cycles. A 3-bit wait-select register chooses one of these intervals. A `clk_stable` output is raised once the flag for the chosen interval is set. Disabling the oscillator, or raising a stop-mode request, clears the counter and every flag.

Top module: `osc_settle_timer`

## Requirements
- R1: After reset the status word reads 8'h00, the wait-select register reads 8'h07, and `clk_stable` is low.
- R2: With `osc_en` high and `stop_req` low, status bit i reads 1 exactly when at least 2^TAP_EXP[i] oscillator cycles have been counted. With both clocks tied together, the status word after system edge n (counting from the edge that samples the enable) equals the flags for max(0, n-5) cycles.
- R3: The flags fill from bit 7 downward and never show a set bit below a clear one. A count between the bit-5 and bit-4 thresholds reads 8'b1110_0000.
- R4: The counter saturates at 2^TAP_EXP[0] and never wraps, so the status word stays 8'hFF for as long as the oscillator keeps running.
- R5: Dropping `osc_en` clears the counter and all flags. The status word reads 8'h00 from the sixth system edge after the drop, and counting restarts from zero on the next enable.
- R6: A high `stop_req` acts exactly like a disabled oscillator, even while `osc_en` is high. After it is released, counting restarts from zero with the R2 timing.
- R7: A write to address 1 stores `reg_wdata[2:0]` as the wait code, and address 1 reads back with bits 7..3 as zero. A write to address 0, the read-only status word, changes nothing.
- R8: The wait codes 0 to 7 select status bits 7 down to 0. `clk_stable` equals the selected status bit and follows a change of code in the same cycle the code is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock that drives the counter |
| sys_clk | input | 1 | System clock for the register port and outputs |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously in each domain |
| osc_en | input | 1 | Oscillator enable (system domain); low means stopped |
| stop_req | input | 1 | Stop-mode request (system domain); high forces the stopped state |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status word, 1 = wait-select register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| clk_stable | output | 1 | High when the selected elapsed-time flag is set |

## Verification
A status flag lands five system edges after the edge that first samples the enable plus its threshold count. The path is one request register, two synchronizer stages, the counter with its flag register, and two more synchronizer stages. A clear lands on the sixth edge after a drop. Reads and `clk_stable` are combinational on registered state, so a new wait code shows in the same cycle as its write edge. The bench ties both clocks together so these counts are exact. It samples on the falling edge after each rising edge and compares against thermometer values it computes from its own copy of the interval exponents.

// File: rtl/ost_pkg.sv
package ost_pkg;
  localparam int unsigned FLAG_N = 8;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned EXP_W  = 5;

  typedef logic [FLAG_N-1:0] flag_vec_t;
  typedef logic [SEL_W-1:0]  wait_code_t;

  typedef enum logic {
    RA_STATUS  = 1'b0,
    RA_WAITSEL = 1'b1
  } reg_addr_e;

  localparam wait_code_t WAIT_CODE_RST = 3'b111;

  // wait code c selects status bit FLAG_N-1-c
  function automatic wait_code_t code_to_bit(input wait_code_t c);
    return wait_code_t'(FLAG_N - 1) - c;
  endfunction
endpackage

// File: rtl/ost_rst_sync.sv
module ost_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ost_bit_sync.sv
module ost_bit_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/ost_settle_cnt.sv
module ost_settle_cnt
  import ost_pkg::*;
#(
  parameter logic [FLAG_N-1:0][EXP_W-1:0] TAP_EXP =
    {5'd8, 5'd9, 5'd10, 5'd11, 5'd13, 5'd15, 5'd17, 5'd18}
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_i,
  output flag_vec_t flags_o
);
  localparam int unsigned CNT_W = int'(TAP_EXP[0]) + 1;
  localparam logic [CNT_W-1:0] CNT_SAT = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  flag_vec_t        flag_d;
  flag_vec_t        flag_q;

  // next count: clear when stopped, hold at saturation
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!run_i) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != CNT_SAT) begin
      cnt_d  = cnt_q + CNT_ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // flag g set once the count reaches 2^TAP_EXP[g]; saturation keeps the compare exact
  for (genvar g = 0; g < FLAG_N; g++) begin : g_tap
    localparam int unsigned LO = int'(TAP_EXP[g]);
    assign flag_d[g] = |cnt_d[CNT_W-1:LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags_o = flag_q;

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT);

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cnt_q == CNT_SAT) |=> (cnt_q == CNT_SAT));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

  for (genvar t = 0; t < FLAG_N - 1; t++) begin : g_thermo_chk
    p_flag_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[t] |-> flag_q[t+1]);
  end
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
  import ost_pkg::*;
#(
  parameter logic [FLAG_N-1:0][EXP_W-1:0] TAP_EXP =
    {5'd8, 5'd9, 5'd10, 5'd11, 5'd13, 5'd15, 5'd17, 5'd18}
) (
  input  logic       osc_clk,
  input  logic       sys_clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       stop_req,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       clk_stable
);
  logic       sys_rst_n;
  logic       osc_rst_n;
  logic       run_req_d;
  logic       run_req_q;
  logic       run_osc;
  flag_vec_t  flags_osc;
  flag_vec_t  status_s;
  wait_code_t sel_q;
  wait_code_t sel_d;
  logic       sel_en;
  reg_addr_e  addr_e;
  logic       unused_wdata;

  ost_rst_sync u_sys_rst (.clk(sys_clk), .arst_n(rst_n), .rst_n_sync(sys_rst_n));
  ost_rst_sync u_osc_rst (.clk(osc_clk), .arst_n(rst_n), .rst_n_sync(osc_rst_n));

  // run request registered in the system domain so the crossing sees no glitch
  always_comb begin
    run_req_d = osc_en & ~stop_req;
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) run_req_q <= 1'b0;
    else            run_req_q <= run_req_d;
  end

  ost_bit_sync #(.WIDTH(1)) u_run_sync (
    .clk(osc_clk), .rst_n(osc_rst_n), .d_i(run_req_q), .q_o(run_osc)
  );

  ost_settle_cnt #(.TAP_EXP(TAP_EXP)) u_cnt (
    .clk(osc_clk), .rst_n(osc_rst_n), .run_i(run_osc), .flags_o(flags_osc)
  );

  // thermometer flags: each bit crosses on its own without a false intermediate
  ost_bit_sync #(.WIDTH(FLAG_N)) u_flag_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d_i(flags_osc), .q_o(status_s)
  );

  assign addr_e       = reg_addr_e'(reg_addr);
  assign unused_wdata = ^reg_wdata[7:SEL_W];

  always_comb begin
    sel_en = reg_wr && (addr_e == RA_WAITSEL);
    sel_d  = reg_wdata[SEL_W-1:0];
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n)  sel_q <= WAIT_CODE_RST;
    else if (sel_en) sel_q <= sel_d;
  end

  always_comb begin
    case (addr_e)
      RA_WAITSEL: reg_rdata = {{(8-SEL_W){1'b0}}, sel_q};
      default:    reg_rdata = status_s;
    endcase
  end

  assign clk_stable = status_s[code_to_bit(sel_q)];

  p_sel_pad_zero_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (addr_e == RA_WAITSEL) |-> (reg_rdata[7:SEL_W] == '0));

  p_sel_hold_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !(reg_wr && addr_e == RA_WAITSEL) |=> $stable(sel_q));

  p_stable_implies_first_r8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    clk_stable |-> status_s[FLAG_N-1]);

  for (genvar t = 0; t < FLAG_N - 1; t++) begin : g_status_chk
    p_status_order_r3: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      status_s[t] |-> status_s[t+1]);
  end
endmodule

// File: tb/osc_settle_timer_test.sv
`timescale 1ns/1ps
module osc_settle_timer_test;
  // small configuration: exponents 3,4,5,6,8,10,12,13 for bits 7..0
  localparam logic [7:0][4:0] TAPS = {5'd3, 5'd4, 5'd5, 5'd6, 5'd8, 5'd10, 5'd12, 5'd13};
  localparam int SAT = 1 << 13;
  localparam int LAT = 5;
  localparam int WATCHDOG = 150000;

  logic       clk;
  logic       rst_n;
  logic       osc_en;
  logic       stop_req;
  logic       reg_wr;
  logic       reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       clk_stable;

  int nvec;
  int nbad;
  int cyc;
  bit done;

  osc_settle_timer #(.TAP_EXP(TAPS)) uut (
    .osc_clk(clk), .sys_clk(clk), .rst_n(rst_n), .osc_en(osc_en),
    .stop_req(stop_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_stable(clk_stable)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] therm(input int k);
    logic [7:0] v;
    int e [8];
    e = '{13, 12, 10, 8, 6, 5, 4, 3}; // index = status bit
    for (int i = 0; i < 8; i++) v[i] = (k >= (1 << e[i]));
    return v;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 1'b0;
    #1;
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG && !done) begin
        nvec++; nbad++;
        $display("FAIL watchdog: got %0d expected <= %0d cycles", cyc, WATCHDOG);
        report();
      end
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] e;
    nvec = 0; nbad = 0; done = 0;
    rst_n = 1'b0; osc_en = 1'b0; stop_req = 1'b0;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk(v, 8'h00, "R1 status");
    rd(1'b1, v); chk(v, 8'h07, "R1 waitsel");
    chk({7'd0, clk_stable}, 8'h00, "R1 stable");

    // R7 write path, upper bits dropped, status write ignored
    for (int c = 0; c < 8; c++) begin
      wr(1'b1, 8'hA8 | 8'(c));
      rd(1'b1, v); chk(v, 8'(c), "R7 waitsel readback");
    end
    wr(1'b0, 8'hFF);
    rd(1'b0, v); chk(v, 8'h00, "R7 status write ignored");
    rd(1'b1, v); chk(v, 8'h07, "R7 waitsel kept");

    // R2/R3/R4/R5/R8 sweep for every wait code
    for (int c = 0; c < 8; c++) begin
      wr(1'b1, 8'(c));
      reg_addr = 1'b0;
      osc_en = 1'b1;
      for (int n = 1; n <= SAT + LAT + ((c == 7) ? 3000 : 20); n++) begin
        int k;
        @(negedge clk);
        k = (n > LAT) ? n - LAT : 0;
        if (k > SAT) k = SAT;
        e = therm(k);
        if (k > SAT - 1 && n > SAT + LAT) chk(reg_rdata, 8'hFF, "R4 saturated");
        else chk(reg_rdata, e, "R2 status");
        chk({7'd0, clk_stable}, {7'd0, e[7-c]}, "R8 stable");
        if (k == 40) chk(reg_rdata, 8'hE0, "R3 thermometer");
      end
      osc_en = 1'b0;
      for (int n = 1; n <= 8; n++) begin
        @(negedge clk);
        chk(reg_rdata, (n <= LAT) ? 8'hFF : 8'h00, "R5 clear");
      end
    end

    // R6 stop request overrides enable
    wr(1'b1, 8'd3);
    osc_en = 1'b1;
    for (int n = 1; n <= 100; n++) @(negedge clk);
    chk(reg_rdata, therm(95), "R2 partial");
    chk({7'd0, clk_stable}, 8'h01, "R8 code3 stable");
    stop_req = 1'b1;
    for (int n = 1; n <= 50; n++) begin
      @(negedge clk);
      if (n >= LAT + 1) begin
        chk(reg_rdata, 8'h00, "R6 stop clears");
        chk({7'd0, clk_stable}, 8'h00, "R6 stable low");
      end
    end
    stop_req = 1'b0;
    for (int n = 1; n <= 300; n++) begin
      @(negedge clk);
      chk(reg_rdata, therm((n > LAT) ? n - LAT : 0), "R6 restart");
    end

    // R8 code change takes effect on the write edge
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'd4;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0;
    chk({7'd0, clk_stable}, {7'd0, therm(296)[3]}, "R8 code switch");
    osc_en = 1'b0;
    repeat (4) @(negedge clk);

    done = 1;
    report();
  end
endmodule